// File: doc/BRIEF.md
# Dual-Channel Converter Input Demultiplexer

This block is the digital front end of a dual 10-bit current-steering converter. It takes parallel sample words, holds each in an input latch, and hands one registered code per channel to the converter cores. For each channel it also drives the complementary code that the opposite current output needs. A mode pin chooses between two ways of feeding the block. Dual-bus mode gives each channel its own data port, write strobe and update strobe. Interleaved mode sends alternating I and Q words over port A, and a select line steers each word to the A or the B latch.

All timing events are single-cycle enable strobes sampled on one system clock. In interleaved mode the shared update strobe passes through a divide-by-two toggle. An alignment input holds that toggle in its low phase, so that the first update after release always loads a matched I/Q pair. While the sleep input is high, the converter latches are frozen and the outputs sit at mid-scale. The input side keeps capturing words during sleep.

Top module: `dacdm_top`

## Requirements
- R1: While `rst` is high at a clock edge, all latches clear after that edge: `code_a`/`code_b` read 0 and `code_a_n`/`code_b_n` read 1023.
- R2: On every cycle, each complement output equals 1023 minus the code output of the same channel.
- R3: In dual-bus mode (`dual_mode`=1), a `wr_a` (`wr_b`) pulse captures `port_a` (`port_b`) into that channel's input latch. Codes are straight offset binary with bit 9 as MSB and pass through unchanged.
- R4: In dual-bus mode, an `upd_a` (`upd_b`) pulse copies the channel's input latch, as it stood before that edge, into its converter latch. The code outputs show the converter latch one cycle later. A write and an update pulsed in the same cycle therefore convert the previously written word.
- R5: In dual-bus mode, the strobes of one channel never change the other channel's latches or outputs.
- R6: In interleaved mode (`dual_mode`=0), a `wr_a` pulse loads `port_a` into the A input latch when `sel_iq`=1 and into the B input latch when `sel_iq`=0. The other latch keeps its value. `port_b`, `wr_b` and `upd_b` have no effect.
- R7: In interleaved mode, in the cycle after each `wr_a` pulse, both input latches are copied together into a transfer pair.
- R8: In interleaved mode, a divider bit toggles on each `upd_a` pulse. Both converter latches load the transfer pair only on pulses where the divider was 0. The divider is 0 in dual-bus mode.
- R9: While `align_rst` is high, the divider is forced to 0 and no interleaved converter load occurs. The first `upd_a` after release loads the pair.
- R10: While `sleep` is high, the converter latches hold and the outputs read 512 (complement 511) from the next cycle on. The input latches and the transfer pair keep running. One cycle after `sleep` falls, the outputs show the held converter codes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = dual-bus, 0 = interleaved |
| sleep | input | 1 | Freeze converter latches, force mid-scale outputs |
| port_a | input | 10 | Data port A (carries both channels when interleaved) |
| port_b | input | 10 | Data port B (dual-bus only) |
| wr_a | input | 1 | Write strobe A / shared write strobe |
| upd_a | input | 1 | Update strobe A / shared update strobe |
| wr_b | input | 1 | Write strobe B (dual-bus only) |
| upd_b | input | 1 | Update strobe B (dual-bus only) |
| sel_iq | input | 1 | Interleaved steering: 1 = A latch, 0 = B latch |
| align_rst | input | 1 | Holds the update divider in its low phase |
| code_a | output | 10 | Channel A converter code |
| code_a_n | output | 10 | Channel A complementary code |
| code_b | output | 10 | Channel B converter code |
| code_b_n | output | 10 | Channel B complementary code |

## Verification
On every cycle, the assertions check the complement relation, the mid-scale forcing and converter freeze during sleep, and the absence of converter loads while the alignment input is high. They also check that channel B keeps its state when its own strobe is idle in dual-bus mode, and that the B input latch holds when it is not selected in interleaved mode. I/Q pairing, where only every second update pulse loads and both channels load the same matched pair, can only be shown by the bench scenarios. The same holds for the exact conversion latency and for recovery of the held codes after sleep, because these depend on sequences of strobes across many cycles.

// File: rtl/dacdm_pkg.sv
package dacdm_pkg;
  localparam int unsigned DACDM_CHANNELS = 2;

  typedef enum logic {
    BUS_INTERLEAVED = 1'b0,
    BUS_DUAL        = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/dacdm_ingress.sv
module dacdm_ingress #(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_dual,
  input  logic [DW-1:0] port_a,
  input  logic [DW-1:0] port_b,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          sel_iq,
  output logic [DW-1:0] lat_a,
  output logic [DW-1:0] lat_b,
  output logic [DW-1:0] pair_a,
  output logic [DW-1:0] pair_b
);
  logic wr_q;

  // input latches: own ports in dual-bus mode, steered port A when interleaved
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_a <= '0;
      lat_b <= '0;
    end else if (is_dual) begin
      if (wr_a) lat_a <= port_a;
      if (wr_b) lat_b <= port_b;
    end else if (wr_a) begin
      if (sel_iq) lat_a <= port_a;
      else        lat_b <= port_a;
    end
  end

  // transfer pair: loaded the cycle after a write (trailing edge of the strobe)
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      pair_a <= '0;
      pair_b <= '0;
    end else begin
      wr_q <= wr_a;
      if (!is_dual && wr_q) begin
        pair_a <= lat_a;
        pair_b <= lat_b;
      end
    end
  end
endmodule

// File: rtl/dacdm_upd_div.sv
module dacdm_upd_div (
  input  logic clk,
  input  logic rst,
  input  logic is_dual,
  input  logic upd_a,
  input  logic upd_b,
  input  logic align_rst,
  output logic ld_a,
  output logic ld_b
);
  logic div_q;
  logic iq_load;

  always_ff @(posedge clk) begin
    if (rst || align_rst || is_dual) div_q <= 1'b0;
    else if (upd_a)                  div_q <= ~div_q;
  end

  // rising edge of the divided update clock
  assign iq_load = upd_a && !align_rst && !div_q;
  assign ld_a    = is_dual ? upd_a : iq_load;
  assign ld_b    = is_dual ? upd_b : iq_load;
endmodule

// File: rtl/dacdm_chan.sv
module dacdm_chan #(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          load,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] core,
  output logic [DW-1:0] code,
  output logic [DW-1:0] code_n
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      core   <= '0;
      code   <= '0;
      code_n <= '1;
    end else begin
      if (load && !sleep) core <= src;
      if (sleep) begin
        code   <= MID;
        code_n <= ~MID;
      end else begin
        code   <= core;
        code_n <= ~core;
      end
    end
  end
endmodule

// File: rtl/dacdm_top.sv
module dacdm_top #(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dual_mode,
  input  logic          sleep,
  input  logic [DW-1:0] port_a,
  input  logic [DW-1:0] port_b,
  input  logic          wr_a,
  input  logic          upd_a,
  input  logic          wr_b,
  input  logic          upd_b,
  input  logic          sel_iq,
  input  logic          align_rst,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_a_n,
  output logic [DW-1:0] code_b,
  output logic [DW-1:0] code_b_n
);
  import dacdm_pkg::*;
  localparam int unsigned CH = DACDM_CHANNELS;

  logic          is_dual;
  logic [DW-1:0] lat_a, lat_b, pair_a, pair_b;
  logic [DW-1:0] core_a, core_b;
  logic          ld_a, ld_b;
  logic [CH-1:0] ld_w;
  logic [DW-1:0] src_w  [CH];
  logic [DW-1:0] core_w [CH];
  logic [DW-1:0] code_w [CH];
  logic [DW-1:0] cn_w   [CH];

  assign is_dual = (bus_mode_e'(dual_mode) == BUS_DUAL);

  dacdm_ingress #(.DW(DW)) u_ingress (
    .clk(clk), .rst(rst), .is_dual(is_dual),
    .port_a(port_a), .port_b(port_b), .wr_a(wr_a), .wr_b(wr_b), .sel_iq(sel_iq),
    .lat_a(lat_a), .lat_b(lat_b), .pair_a(pair_a), .pair_b(pair_b)
  );

  dacdm_upd_div u_div (
    .clk(clk), .rst(rst), .is_dual(is_dual),
    .upd_a(upd_a), .upd_b(upd_b), .align_rst(align_rst),
    .ld_a(ld_a), .ld_b(ld_b)
  );

  assign ld_w     = {ld_b, ld_a};
  assign src_w[0] = is_dual ? lat_a : pair_a;
  assign src_w[1] = is_dual ? lat_b : pair_b;

  for (genvar g = 0; g < CH; g++) begin : g_chan
    dacdm_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst), .sleep(sleep), .load(ld_w[g]), .src(src_w[g]),
      .core(core_w[g]), .code(code_w[g]), .code_n(cn_w[g])
    );
  end

  assign core_a   = core_w[0];
  assign core_b   = core_w[1];
  assign code_a   = code_w[0];
  assign code_a_n = cn_w[0];
  assign code_b   = code_w[1];
  assign code_b_n = cn_w[1];
endmodule

// File: rtl/dacdm_chk.sv
module dacdm_chk #(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          dual_mode,
  input logic          sleep,
  input logic          align_rst,
  input logic          upd_b,
  input logic          wr_a,
  input logic          sel_iq,
  input logic [DW-1:0] lat_b,
  input logic [DW-1:0] core_a,
  input logic [DW-1:0] core_b,
  input logic [DW-1:0] code_a,
  input logic [DW-1:0] code_a_n,
  input logic [DW-1:0] code_b,
  input logic [DW-1:0] code_b_n
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);
  localparam logic [DW:0]   FULL = {1'b0, {DW{1'b1}}};

  AST_COMPL_A: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, code_a} + {1'b0, code_a_n}) == FULL); // R2
  AST_COMPL_B: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, code_b} + {1'b0, code_b_n}) == FULL); // R2
  AST_SLEEP_MID: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (code_a == MID && code_b == MID)); // R10
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(core_a) && $stable(core_b))); // R10
  AST_ALIGN_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && align_rst) |=> ($stable(core_a) && $stable(core_b))); // R9
  AST_DUAL_B_OWN: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && !upd_b) |=> $stable(core_b)); // R5
  AST_IQ_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && !(wr_a && !sel_iq)) |=> $stable(lat_b)); // R6
endmodule

bind dacdm_top dacdm_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .dual_mode(dual_mode), .sleep(sleep),
  .align_rst(align_rst), .upd_b(upd_b), .wr_a(wr_a), .sel_iq(sel_iq),
  .lat_b(lat_b), .core_a(core_a), .core_b(core_b),
  .code_a(code_a), .code_a_n(code_a_n), .code_b(code_b), .code_b_n(code_b_n)
);

// File: tb/dacdm_top_tb.sv
module dacdm_top_tb;
  localparam int DW = 10;
  localparam int MAXC = 1023;

  logic clk = 1'b0;
  logic rst, dual_mode, sleep, wr_a, upd_a, wr_b, upd_b, sel_iq, align_rst;
  logic [DW-1:0] port_a, port_b;
  logic [DW-1:0] code_a, code_a_n, code_b, code_b_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_la, m_lb, m_pa, m_pb, m_ca, m_cb, m_oa, m_ob;
  bit m_wrq, m_div;

  always #4 clk = ~clk;

  dacdm_top #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .dual_mode(dual_mode), .sleep(sleep),
    .port_a(port_a), .port_b(port_b), .wr_a(wr_a), .upd_a(upd_a),
    .wr_b(wr_b), .upd_b(upd_b), .sel_iq(sel_iq), .align_rst(align_rst),
    .code_a(code_a), .code_a_n(code_a_n), .code_b(code_b), .code_b_n(code_b_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock edge of the requirement-level model
  task automatic model_edge();
    int la, lb, pa, pb, ca, cb, oa, ob;
    bit ld_a, ld_b, iq;
    la = m_la; lb = m_lb; pa = m_pa; pb = m_pb; ca = m_ca; cb = m_cb;
    if (rst) begin
      m_la = 0; m_lb = 0; m_pa = 0; m_pb = 0; m_ca = 0; m_cb = 0;
      m_oa = 0; m_ob = 0; m_wrq = 0; m_div = 0;
      return;
    end
    if (dual_mode) begin
      if (wr_a) m_la = port_a;
      if (wr_b) m_lb = port_b;
    end else if (wr_a) begin
      if (sel_iq) m_la = port_a; else m_lb = port_a;
    end
    if (!dual_mode && m_wrq) begin m_pa = la; m_pb = lb; end
    m_wrq = wr_a;
    iq = upd_a && !align_rst && !m_div;
    ld_a = dual_mode ? upd_a : iq;
    ld_b = dual_mode ? upd_b : iq;
    if (align_rst || dual_mode) m_div = 0;
    else if (upd_a) m_div = ~m_div;
    if (!sleep && ld_a) m_ca = dual_mode ? la : pa;
    if (!sleep && ld_b) m_cb = dual_mode ? lb : pb;
    oa = sleep ? 512 : ca;
    ob = sleep ? 512 : cb;
    m_oa = oa; m_ob = ob;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_a = 0; upd_a = 0; wr_b = 0; upd_b = 0;
  endtask

  task automatic iq_pair(input int a, input int b);
    wr_a = 1; sel_iq = 1; port_a = DW'(a); step();
    sel_iq = 0; port_a = DW'(b); step();
    wr_a = 0; step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; dual_mode = 1; sleep = 0; sel_iq = 0; align_rst = 0;
    port_a = '0; port_b = '0; idle();
    @(negedge clk);
    step(); step(); step();
    chk("R1 code_a", code_a, 0);
    chk("R1 code_a_n", code_a_n, MAXC);
    chk("R1 code_b_n", code_b_n, MAXC);
    rst = 0;

    // R3/R4: write and update together, then update alone
    port_a = 10'h2A5; wr_a = 1; upd_a = 1; step();
    idle(); step();
    chk("R4 same-cycle write uses old word", code_a, 0);
    upd_a = 1; step(); idle(); step();
    chk("R3 code_a", code_a, 10'h2A5);
    chk("R2 code_a_n", code_a_n, MAXC - 10'h2A5);
    chk("R5 channel B untouched", code_b, 0);

    // R6..R8: interleaved pairing
    dual_mode = 0; align_rst = 1; step(); align_rst = 0;
    port_b = 10'h3FF; wr_b = 1; upd_b = 1;
    iq_pair(10'h100, 10'h0F0);
    wr_b = 0; upd_b = 0;
    chk("R6 B strobes ignored", code_b, 0);
    upd_a = 1; step(); upd_a = 0; step();
    chk("R7 pair A", code_a, 10'h100);
    chk("R6 steered B", code_b, 10'h0F0);
    chk("R2 code_b_n", code_b_n, MAXC - 10'h0F0);
    iq_pair(10'h011, 10'h022);
    upd_a = 1; step(); upd_a = 0; step();
    chk("R8 odd update skipped", code_a, 10'h100);
    upd_a = 1; step(); upd_a = 0; step();
    chk("R8 even update loads A", code_a, 10'h011);
    chk("R8 even update loads B", code_b, 10'h022);

    // R9: alignment
    iq_pair(10'h055, 10'h066);
    align_rst = 1; upd_a = 1; step();
    align_rst = 0; upd_a = 0; step();
    chk("R9 no load during align", code_a, 10'h011);
    upd_a = 1; step(); upd_a = 0; step();
    chk("R9 first update loads A", code_a, 10'h055);
    chk("R9 first update loads B", code_b, 10'h066);

    // R10: sleep
    sleep = 1; step(); step();
    chk("R10 mid code", code_a, 512);
    chk("R10 mid complement", code_a_n, 511);
    iq_pair(10'h3C3, 10'h0C3);
    upd_a = 1; step(); step(); upd_a = 0; step();
    chk("R10 still mid", code_b, 512);
    sleep = 0; step();
    chk("R10 held A after wake", code_a, 10'h055);
    chk("R10 held B after wake", code_b, 10'h066);
    upd_a = 1; step(); step(); upd_a = 0; step();
    chk("R10 latches ran during sleep A", code_a, 10'h3C3);
    chk("R10 latches ran during sleep B", code_b, 10'h0C3);

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) dual_mode = $urandom % 2;
      if ($urandom % 40 == 0) sleep = ~sleep;
      align_rst = ($urandom % 20 == 0);
      wr_a = $urandom % 2; upd_a = $urandom % 2;
      wr_b = $urandom % 2; upd_b = $urandom % 2;
      sel_iq = $urandom % 2;
      port_a = DW'($urandom); port_b = DW'($urandom);
      if (i % 97 == 0) port_a = '1;
      if (i % 89 == 0) port_b = '0;
      step();
      if (dual_mode) begin
        chk("R3 R4 random A", code_a, m_oa);
        chk("R5 random B", code_b, m_ob);
      end else begin
        chk("R7 R8 random A", code_a, m_oa);
        chk("R6 random B", code_b, m_ob);
      end
      chk("R2 random A_n", code_a_n, MAXC - m_oa);
      chk("R2 random B_n", code_b_n, MAXC - m_ob);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule